// File: doc/BRIEF.md
# Serial Flash Write-Enable Command Front-End

This block is the slave-side instruction front-end of a serial NOR flash. It watches the chip select, serial clock and serial data input pins. It collects an 8-bit instruction code and decides, when the frame closes, whether a command that changes memory or status may go ahead. The three pins are oversampled by a fast system clock through synchronizer chains, so the serial clock may idle low or high between frames.

Two enables are kept. The write-enable latch is set by one instruction and is consumed by the first accepted program, erase or status-write command. The volatile-write flag is a one-shot. It leaves the latch alone and only steers the next status-register write towards the volatile copy of the status bits. Downstream logic receives a single-cycle permission strobe for each accepted command, and the two flag bits for the status register.

Top module: `spi_wren_frontend`

## Requirements
- R1: After reset, welBit and volWenBit are 0, all four grant strobes are 0, and sdoEn is 0.
- R2: A frame with code 8'h06 sets welBit to 1 and leaves volWenBit unchanged.
- R3: A frame with code 8'h50 sets volWenBit to 1 and leaves welBit unchanged.
- R4: A gated command arriving while welBit is 0 is ignored. This covers the program codes 8'h02, 8'h32 and 8'h42, the erase codes 8'h20, 8'hD8, 8'hC7, 8'h60 and 8'h44, and the status-write code 8'h01. No grant strobe is raised and welBit stays 0.
- R5: A program code (8'h02, 8'h32, 8'h42) accepted with welBit 1 raises progGrant for exactly one clock and clears welBit.
- R6: An erase code (8'h20, 8'hD8, 8'hC7, 8'h60, 8'h44) accepted with welBit 1 raises eraseGrant for exactly one clock and clears welBit.
- R7: Code 8'h01 accepted with welBit 1 raises statusWriteVolGrant when volWenBit is 1, and statusWriteNvGrant otherwise, for exactly one clock. It then clears both welBit and volWenBit.
- R8: Any complete frame whose code is neither 8'h06 nor 8'h50 clears volWenBit. This includes ignored gated commands and unknown codes.
- R9: Bits are taken most significant first on rising serial clock edges while csN is low. A frame is decoded when csN rises after exactly 8 bits. With any other bit count the frame is discarded and no flag or strobe changes.
- R10: Frames work both with the serial clock idling low (mode 0) and idling high (mode 3).
- R11: The serial output stays undriven (sdoEn 0) at all times, including during every instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output value |
| sdoEn | output | 1 | Output enable for sdo (0 = high impedance) |
| welBit | output | 1 | Write-enable latch, to the status register |
| volWenBit | output | 1 | Volatile status-write enable flag |
| progGrant | output | 1 | One-cycle permission for a program command |
| eraseGrant | output | 1 | One-cycle permission for an erase command |
| statusWriteNvGrant | output | 1 | One-cycle permission for a non-volatile status write |
| statusWriteVolGrant | output | 1 | One-cycle permission for a volatile status write |

## Verification
The assertions check on every cycle that no grant appears unless the latch was set the cycle before, that at most one grant is active at a time, and that the latch is clear after any grant. They also check that raising the volatile flag never disturbs the latch, that a discarded frame changes nothing, and that the bit counter is idle while chip select is high. Only the bench's scenarios can show the opcode-to-strobe mapping, the choice between volatile and non-volatile status writes, the one-shot clearing of the volatile flag by unrelated codes, and correct framing in both clock idle polarities. The bench covers these by comparing against a reference model over directed and random frames, including frames of 7 and 9 bits.

// File: rtl/spi_wren_pkg.sv
package spi_wren_pkg;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_VOLEN   = 8'h50;
  localparam logic [7:0] OP_SRWRITE = 8'h01;

  typedef enum logic [2:0] {
    K_WREN, K_VOLEN, K_SRW, K_PROG, K_ERASE, K_OTHER
  } cmdKind_t;

  // Datapath to control: end-of-frame event
  typedef struct packed {
    logic       done;
    logic       lenOk;
    logic [7:0] op;
  } frameEvt_t;

  // Control outputs: permission strobes
  typedef struct packed {
    logic prog;
    logic erase;
    logic srNv;
    logic srVol;
  } grants_t;

  function automatic cmdKind_t classifyOp(input logic [7:0] op);
    case (op)
      OP_WREN:                        return K_WREN;
      OP_VOLEN:                       return K_VOLEN;
      OP_SRWRITE:                     return K_SRW;
      8'h02, 8'h32, 8'h42:            return K_PROG;
      8'h20, 8'hD8, 8'hC7, 8'h60,
      8'h44:                          return K_ERASE;
      default:                        return K_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_datapath.sv
module spi_cmd_datapath
  import spi_wren_pkg::*;
#(
  parameter int OP_BITS     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      sdi,
  output frameEvt_t evt
);
  localparam int CNT_W   = $clog2(OP_BITS + 2);
  localparam int CNT_SAT = OP_BITS + 1;

  logic [SYNC_STAGES-1:0] csSync, sclkSync, sdiSync;
  logic csS, sclkS, sdiS;
  logic csPrev, sclkPrev;
  logic sclkRise, csRise;
  logic [OP_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;

  // Synchronizer chains, one per serial pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= '1;
      sclkSync <= '0;
      sdiSync  <= '0;
    end else begin
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      sdiSync  <= {sdiSync[SYNC_STAGES-2:0], sdi};
    end
  end

  assign csS   = csSync[SYNC_STAGES-1];
  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign sdiS  = sdiSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign sclkRise = sclkS && !sclkPrev && !csS;
  assign csRise   = csS && !csPrev;

  // Opcode shifter, MSB first, and saturating bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (csS) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      shiftReg <= {shiftReg[OP_BITS-2:0], sdiS};
      if (bitCnt != CNT_W'(CNT_SAT)) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evt <= '0;
    end else begin
      evt.done  <= csRise;
      evt.lenOk <= (bitCnt == CNT_W'(OP_BITS));
      evt.op    <= shiftReg[7:0];
    end
  end

  AST_CNT_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (csS && csPrev) |=> (bitCnt == '0)); // R9

endmodule

// File: rtl/spi_cmd_control.sv
module spi_cmd_control
  import spi_wren_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  frameEvt_t evt,
  output logic      wel,
  output logic      volWen,
  output grants_t   grants
);
  cmdKind_t kind;
  logic     accept;

  assign kind   = classifyOp(evt.op);
  assign accept = evt.done && evt.lenOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel    <= 1'b0;
      volWen <= 1'b0;
      grants <= '0;
    end else begin
      grants <= '0;
      if (accept) begin
        case (kind)
          K_WREN:  wel <= 1'b1;
          K_VOLEN: volWen <= 1'b1;
          K_SRW: begin
            volWen <= 1'b0;
            if (wel) begin
              wel          <= 1'b0;
              grants.srVol <= volWen;
              grants.srNv  <= !volWen;
            end
          end
          K_PROG: begin
            volWen <= 1'b0;
            if (wel) begin
              wel         <= 1'b0;
              grants.prog <= 1'b1;
            end
          end
          K_ERASE: begin
            volWen <= 1'b0;
            if (wel) begin
              wel          <= 1'b0;
              grants.erase <= 1'b1;
            end
          end
          default: volWen <= 1'b0;
        endcase
      end
    end
  end

  AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    (|grants) |-> $past(wel)); // R4
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grants)); // R7
  AST_WEL_CLEARED_BY_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (|grants) |-> !wel); // R5
  AST_VOLEN_KEEPS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(volWen) |-> $stable(wel)); // R3
  AST_DISCARD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (evt.done && !evt.lenOk) |=> ($stable(wel) && $stable(volWen) && grants == '0)); // R9

endmodule

// File: rtl/spi_wren_frontend.sv
module spi_wren_frontend
  import spi_wren_pkg::*;
#(
  parameter int OP_BITS     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdoEn,
  output logic welBit,
  output logic volWenBit,
  output logic progGrant,
  output logic eraseGrant,
  output logic statusWriteNvGrant,
  output logic statusWriteVolGrant
);
  frameEvt_t evt;
  grants_t   grants;

  spi_cmd_datapath #(.OP_BITS(OP_BITS), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .evt(evt)
  );

  spi_cmd_control uCtrl (
    .clk(clk), .rstN(rstN), .evt(evt),
    .wel(welBit), .volWen(volWenBit), .grants(grants)
  );

  // None of these instructions returns data: output stays released
  assign sdo   = 1'b0;
  assign sdoEn = 1'b0;

  assign progGrant           = grants.prog;
  assign eraseGrant          = grants.erase;
  assign statusWriteNvGrant  = grants.srNv;
  assign statusWriteVolGrant = grants.srVol;

endmodule

// File: tb/tb_spi_wren_frontend.sv
module tb_spi_wren_frontend;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdoEn, welBit, volWenBit;
  logic progGrant, eraseGrant, statusWriteNvGrant, statusWriteVolGrant;

  int checks = 0, fails = 0;
  int progCnt = 0, eraseCnt = 0, nvCnt = 0, volCnt = 0;
  int expProg = 0, expErase = 0, expNv = 0, expVol = 0;
  bit expWel = 0, expVolWen = 0;
  bit sdoEnSeen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_wren_frontend dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoEn(sdoEn), .welBit(welBit), .volWenBit(volWenBit),
    .progGrant(progGrant), .eraseGrant(eraseGrant),
    .statusWriteNvGrant(statusWriteNvGrant),
    .statusWriteVolGrant(statusWriteVolGrant)
  );

  // Strobe counters sampled away from the active edge
  always @(negedge clk) begin
    if (progGrant)           progCnt++;
    if (eraseGrant)          eraseCnt++;
    if (statusWriteNvGrant)  nvCnt++;
    if (statusWriteVolGrant) volCnt++;
    if (rstN && sdoEn)       sdoEnSeen = 1;
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int kindOf(input logic [7:0] op);
    case (op)
      8'h06: return 0;
      8'h50: return 1;
      8'h01: return 2;
      8'h02, 8'h32, 8'h42: return 3;
      8'h20, 8'hD8, 8'hC7, 8'h60, 8'h44: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic model(input logic [7:0] op, input int nb);
    if (nb != 8) return;
    case (kindOf(op))
      0: expWel = 1;
      1: expVolWen = 1;
      2: begin
        if (expWel) begin
          if (expVolWen) expVol++; else expNv++;
          expWel = 0;
        end
        expVolWen = 0;
      end
      3: begin if (expWel) begin expProg++; expWel = 0; end expVolWen = 0; end
      4: begin if (expWel) begin expErase++; expWel = 0; end expVolWen = 0; end
      default: expVolWen = 0;
    endcase
  endtask

  task automatic sendFrame(input logic [7:0] op, input int nb, input bit mode3, input string tag);
    sclk = mode3;
    waitClk(4);
    csN = 1'b0;
    waitClk(4);
    for (int i = 0; i < nb; i++) begin
      sclk = 1'b0;
      sdi  = op[7 - (i % 8)];
      waitClk(4);
      sclk = 1'b1;
      waitClk(4);
    end
    if (!mode3) sclk = 1'b0;
    waitClk(4);
    csN = 1'b1;
    waitClk(10);
    model(op, nb);
    check(tag, welBit, expWel, "welBit");
    check(tag, volWenBit, expVolWen, "volWenBit");
    check(tag, progCnt, expProg, "progGrant count");
    check(tag, eraseCnt, expErase, "eraseGrant count");
    check(tag, nvCnt, expNv, "statusWriteNvGrant count");
    check(tag, volCnt, expVol, "statusWriteVolGrant count");
  endtask

  localparam logic [7:0] POOL [14] = '{8'h06, 8'h50, 8'h01, 8'h02, 8'h32, 8'h42,
    8'h20, 8'hD8, 8'hC7, 8'h60, 8'h44, 8'h05, 8'h9F, 8'hAB};

  initial begin
    void'($urandom(32'h5eed));
    waitClk(3);
    // R1: reset state
    check("R1", welBit, 0, "welBit at reset");
    check("R1", volWenBit, 0, "volWenBit at reset");
    check("R1", progGrant | eraseGrant | statusWriteNvGrant | statusWriteVolGrant, 0, "strobes at reset");
    rstN = 1'b1;
    waitClk(3);

    sendFrame(8'h02, 8, 0, "R4");      // program without latch
    sendFrame(8'h01, 8, 0, "R4");      // status write without latch
    sendFrame(8'h06, 8, 0, "R2");
    sendFrame(8'h50, 8, 0, "R3");      // latch must stay 1
    sendFrame(8'h01, 8, 0, "R7");      // volatile status write
    sendFrame(8'h06, 8, 0, "R2");
    sendFrame(8'h01, 8, 0, "R7");      // non-volatile status write
    sendFrame(8'h06, 8, 0, "R5");
    sendFrame(8'h32, 8, 0, "R5");
    sendFrame(8'h06, 8, 1, "R10");
    sendFrame(8'hD8, 8, 1, "R6");      // erase in mode 3
    sendFrame(8'h06, 7, 0, "R9");      // short frame discarded
    sendFrame(8'h06, 9, 1, "R9");      // long frame discarded
    sendFrame(8'h50, 8, 1, "R3");
    sendFrame(8'h9F, 8, 0, "R8");      // unknown code clears volatile flag
    sendFrame(8'h50, 8, 0, "R3");
    sendFrame(8'h20, 8, 0, "R8");      // ignored erase also clears it

    for (int n = 0; n < 80; n++) begin
      logic [7:0] op;
      int nb;
      int r;
      op = POOL[$urandom_range(13, 0)];
      r  = $urandom_range(7, 0);
      nb = (r == 0) ? 7 : (r == 1) ? 9 : 8;
      sendFrame(op, nb, bit'($urandom_range(1, 0)), "R9");
    end

    check("R11", int'(sdoEnSeen), 0, "sdoEn driven");
    check("R11", int'(sdo), 0, "sdo value");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule